// File: doc/BRIEF.md
# Seven-Segment Rotating Light Sequencer

This block drives a single seven-segment digit so that a lit spot seems to circle the outer ring of the digit. A Moore state machine walks through twelve states. In six of them one outer segment is lit. In the other six, two neighbouring segments are lit, which forms a brief hand-over from one segment to the next. Because the machine is Moore, the drive word depends only on the present state.

A single up-counting timer sets how long each state lasts. Single-segment states hold for a long interval. With a 50 MHz clock the default is 6,000,000 cycles, or 120 ms. Hand-over states hold for a short interval: 1,750,000 cycles, or 35 ms, by default. A stop input freezes the timer and the state together. The pattern then stays on the digit until stop is released, and the interrupted interval resumes from the count it had reached.

Top module: `segment_rotator`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, puts the machine in the state where only segment a is lit and clears the timer. After reset is released, that state lasts a full long interval.
- R2: States follow this order: a, a+b, b, b+c, c, c+d, d, d+e, e, e+f, f, f+a. After f+a the machine wraps back to a.
- R3: The drive word `seg_n` is active-low, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. A lit segment drives 0. Bit 6 (g) is 1 in every state. Exactly one or two of bits 5:0 are 0.
- R4: While `stop` is high, neither the state nor the timer count changes, so `seg_n` holds. When `stop` is released, the current state finishes whatever remains of its interval.
- R5: Every single-segment state lasts exactly `LONG_CYC` clock cycles.
- R6: Every two-segment state lasts exactly `SHORT_CYC` clock cycles.
- R7: If `stop` is high on the edge that would end a state, that edge does not advance the machine. The machine advances on the first edge at which `stop` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop | input | 1 | Freeze request, active high |
| seg_n | output | 7 | Active-low segment drive, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with `LONG_CYC` = 5 and `SHORT_CYC` = 2. With these values, two full laps of the ring fit in a few dozen cycles. Every cycle of every state can then be sampled, so the bench confirms both the order of the states and the exact length of each interval. The short intervals also make it possible to place `stop` on chosen timer counts, including the final count of a state, and to place a reset in the middle of a lap.

// File: rtl/segment_rotator_pkg.sv
package segment_rotator_pkg;

    localparam int SEG_W     = 7;
    localparam int RING_LEN  = 6;
    localparam int STATE_CNT = 2 * RING_LEN;

    typedef enum logic [3:0] {
        ST_A  = 4'd0,  ST_AB = 4'd1,
        ST_B  = 4'd2,  ST_BC = 4'd3,
        ST_C  = 4'd4,  ST_CD = 4'd5,
        ST_D  = 4'd6,  ST_DE = 4'd7,
        ST_E  = 4'd8,  ST_EF = 4'd9,
        ST_F  = 4'd10, ST_FA = 4'd11
    } rot_state_t;

    typedef logic [SEG_W-1:0] seg_word_t;

    // Active-high mask with one outer segment set, index 0 = a .. 5 = f.
    function automatic seg_word_t ring_bit(input int unsigned pos);
        seg_word_t m;
        m = '0;
        m[pos % RING_LEN] = 1'b1;
        return m;
    endfunction

    // Convert a lit mask into the active-low drive word; g stays dark.
    function automatic seg_word_t to_drive(input seg_word_t lit);
        seg_word_t w;
        w = ~lit;
        w[SEG_W-1] = 1'b1;
        return w;
    endfunction

    // Single-segment states hold for the long interval.
    function automatic logic is_long_state(input rot_state_t s);
        return (s[0] == 1'b0);
    endfunction

endpackage

// File: rtl/rot_dwell_timer.sv
module rot_dwell_timer #(
    parameter int LONG_CYC  = 6_000_000,
    parameter int SHORT_CYC = 1_750_000
) (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    input  logic long_sel,
    output logic step
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = long_sel ? LIM_LONG : LIM_SHORT;
    assign step  = !stop && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (stop) cnt <= cnt;
        else if (step) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R4: a held timer does not move
    p_count_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(cnt));
    // R5 / R6: count never runs past the limit of the current interval
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);
    // R1: reset clears the count
    p_count_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/rot_step_logic.sv
module rot_step_logic
    import segment_rotator_pkg::*;
(
    input  rot_state_t cur,
    output rot_state_t nxt,
    output seg_word_t  seg_n,
    output logic       long_sel
);
    always_comb begin
        long_sel = is_long_state(cur);
        case (cur)
            ST_A:    begin seg_n = to_drive(ring_bit(0));               nxt = ST_AB; end
            ST_AB:   begin seg_n = to_drive(ring_bit(0) | ring_bit(1)); nxt = ST_B;  end
            ST_B:    begin seg_n = to_drive(ring_bit(1));               nxt = ST_BC; end
            ST_BC:   begin seg_n = to_drive(ring_bit(1) | ring_bit(2)); nxt = ST_C;  end
            ST_C:    begin seg_n = to_drive(ring_bit(2));               nxt = ST_CD; end
            ST_CD:   begin seg_n = to_drive(ring_bit(2) | ring_bit(3)); nxt = ST_D;  end
            ST_D:    begin seg_n = to_drive(ring_bit(3));               nxt = ST_DE; end
            ST_DE:   begin seg_n = to_drive(ring_bit(3) | ring_bit(4)); nxt = ST_E;  end
            ST_E:    begin seg_n = to_drive(ring_bit(4));               nxt = ST_EF; end
            ST_EF:   begin seg_n = to_drive(ring_bit(4) | ring_bit(5)); nxt = ST_F;  end
            ST_F:    begin seg_n = to_drive(ring_bit(5));               nxt = ST_FA; end
            ST_FA:   begin seg_n = to_drive(ring_bit(5) | ring_bit(0)); nxt = ST_A;  end
            default: begin seg_n = to_drive(ring_bit(0));               nxt = ST_A;  end
        endcase
    end

    // R3: g dark and one or two outer segments lit
    always_comb begin
        a_g_dark_r3: assert (seg_n[SEG_W-1] == 1'b1);
        a_lit_count_r3: assert ($countones(~seg_n[SEG_W-2:0]) inside {1, 2});
    end

endmodule

// File: rtl/rot_state_reg.sv
module rot_state_reg
    import segment_rotator_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    input  logic       step,
    input  rot_state_t nxt,
    output rot_state_t cur
);
    always_ff @(posedge clk) begin
        if (rst)       cur <= ST_A;
        else if (step) cur <= nxt;
    end

    // R1: reset lands on segment a alone
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (cur == ST_A));
    // R4 / R7: stop blocks any state change
    p_state_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(cur));
    // R2: a step always moves to a different state
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> (cur != $past(cur)));

endmodule

// File: rtl/segment_rotator.sv
module segment_rotator #(
    parameter int LONG_CYC  = 6_000_000,
    parameter int SHORT_CYC = 1_750_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop,
    output logic [6:0] seg_n
);
    import segment_rotator_pkg::*;

    rot_state_t cur, nxt;
    seg_word_t  drive;
    logic       long_sel;
    logic       step;

    rot_dwell_timer #(
        .LONG_CYC (LONG_CYC),
        .SHORT_CYC(SHORT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .stop    (stop),
        .long_sel(long_sel),
        .step    (step)
    );

    rot_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .stop(stop),
        .step(step),
        .nxt (nxt),
        .cur (cur)
    );

    rot_step_logic u_logic (
        .cur     (cur),
        .nxt     (nxt),
        .seg_n   (drive),
        .long_sel(long_sel)
    );

    assign seg_n = drive;

    // R4: output held while frozen
    p_seg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(seg_n));
    // R3: segment g never lit
    p_g_off_r3: assert property (@(posedge clk) disable iff (rst)
        seg_n[6] == 1'b1);

endmodule

// File: tb/segment_rotator_tb.sv
`timescale 1ns/1ps
module segment_rotator_tb;

    localparam int L = 5;
    localparam int S = 2;

    // Expected drive words in rotation order (R2, R3)
    localparam logic [6:0] EXP [12] = '{
        7'h7E, 7'h7C, 7'h7D, 7'h79, 7'h7B, 7'h73,
        7'h77, 7'h67, 7'h6F, 7'h4F, 7'h5F, 7'h5E
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop = 1'b0;
    logic [6:0] seg_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    segment_rotator #(.LONG_CYC(L), .SHORT_CYC(S)) u_dut (
        .clk  (clk),
        .rst  (rst),
        .stop (stop),
        .seg_n(seg_n)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        stop = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Hold for n samples, counting how many show the expected word.
    task automatic hold_count(input logic [6:0] w, input int n, output int good);
        good = 0;
        for (int k = 0; k < n; k++) begin
            if (seg_n == w) good++;
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int good;
        do_reset();
        // R1: home state right after reset
        check(seg_n == 7'h7E, "R1 reset state", seg_n, 7'h7E);

        // Table walk: two laps, every state, every cycle (R2, R3, R5, R6)
        for (int s = 0; s < 24; s++) begin
            int idx;
            int dur;
            idx = s % 12;
            dur = (idx % 2 == 0) ? L : S;
            check(seg_n == EXP[idx], "R2 order", seg_n, EXP[idx]);
            check(seg_n[6] == 1'b1, "R3 g off", seg_n[6], 1);
            hold_count(EXP[idx], dur, good);
            if (idx % 2 == 0)
                check(good == dur, "R5 long dwell", good, dur);
            else
                check(good == dur, "R6 short dwell", good, dur);
        end
        // R2: wrap back to a after f+a
        check(seg_n == 7'h7E, "R2 wrap", seg_n, 7'h7E);

        // R4: freeze in the middle of a state
        do_reset();
        tick(); tick();
        stop = 1'b1;
        hold_count(7'h7E, 10, good);
        check(good == 10, "R4 frozen", good, 10);
        stop = 1'b0;
        hold_count(7'h7E, L - 2, good);
        check(good == L - 2, "R4 resume remainder", good, L - 2);
        check(seg_n == 7'h7C, "R4 advance after resume", seg_n, 7'h7C);

        // R7: stop on the final count of a state
        do_reset();
        for (int k = 0; k < L - 1; k++) tick();
        stop = 1'b1;
        tick(); tick(); tick();
        check(seg_n == 7'h7E, "R7 no advance under stop", seg_n, 7'h7E);
        stop = 1'b0;
        check(seg_n == 7'h7E, "R7 still home before edge", seg_n, 7'h7E);
        tick();
        check(seg_n == 7'h7C, "R7 advance on release", seg_n, 7'h7C);

        // R1: reset mid-lap returns home with a full long dwell
        for (int k = 0; k < S + L + 1; k++) tick();
        check(seg_n == 7'h79, "R2 mid-lap position", seg_n, 7'h79);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check(seg_n == 7'h7E, "R1 reset mid-lap", seg_n, 7'h7E);
        hold_count(7'h7E, L, good);
        check(good == L, "R1 full dwell after reset", good, L);
        check(seg_n == 7'h7C, "R1 advance after dwell", seg_n, 7'h7C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule